// File: doc/BRIEF.md
# Varicode Character Decoder

This block turns a serial stream of decoded data bits into text characters. One bit arrives with each strobe, either straight from the hard-decision stage or from the output of the error-correcting decoder; the block does not care which. Characters have variable length. Each one is a codeword that begins and ends with a one and never holds two zeros in a row. Characters are separated only by an in-band gap of two consecutive zeros, so no bit count or framing word marks their edges.

A framer collects bits into a codeword register until it sees the two-zero gap. A registered lookup stage then maps the collected codeword to an 8-bit character and emits it with a one-cycle valid pulse. A codeword that is not in the table raises an unknown-code pulse and no character. A run of more than twelve codeword bits without a gap raises an overflow pulse. The bits that follow are then dropped until the next gap, and decoding resumes with the first one after that gap.

Top module: `vdec_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `char_valid`, `char_out`, `unknown_code` and `overflow_err` are all 0. A partly collected codeword is discarded, so a later "00" produces no output.
- R2: Zero bits that arrive while no codeword is being collected (after reset or after a gap) produce no output and do not disturb the next character.
- R3: When the second zero of a gap is strobed in, the codeword collected before it is decoded, and exactly one of `char_valid` or `unknown_code` is high for one cycle, one clock edge after that strobe.
- R4: A single zero inside a codeword (a zero followed by a one) does not end the codeword. For example, 1,0,1 then 0,0 decodes to "t".
- R5: `bit_in` is taken only when `bit_valid` is high. With `bit_valid` low, the decoder state does not change, whatever `bit_in` does.
- R6: A codeword that is not in the table (for example 1101101) pulses `unknown_code` and does not pulse `char_valid`.
- R7: If a one would make the codeword longer than 12 bits (a pending single zero counts as a bit), `overflow_err` pulses one edge after that strobe. All bits up to and including the next "00" gap are then discarded without output, and normal decoding resumes after it.
- R8: A codeword of exactly 12 bits followed by a gap raises no overflow. Twelve ones are not in the table, so that codeword gives `unknown_code`.
- R9: Table (codeword bits sent first-to-last → character): 1→space, 11101→LF, 11111→CR, 11→e, 101→t, 111→o, 1011→a, 1101→i, 1111→n, 10101→r, 10111→s, 11011→l, 101011→h, 101101→d, 101111→c, 110111→u, 111011→m, 111101→f, 111111→p, 1011011→g, 1011101→y, 1011111→b, 1101011→w, 1111011→v, 10111111→k, 11011111→x, 111101011→j, 110111111→q, 111010101→z, 10110111→0, 10111101→1, 11101101→2, 11111111→3, 101110111→4, 101011011→5, 101101011→6, 110101101→7, 110101011→8, 110110111→9.
- R10: With strobes on every cycle, an output pulse can fall in the same cycle as the first bit of the next character. No bit is lost, and consecutive characters come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: `bit_in` holds a new bit this cycle |
| bit_in | input | 1 | Serial data bit |
| char_valid | output | 1 | One-cycle pulse: `char_out` holds a new character |
| char_out | output | 8 | Decoded character code |
| unknown_code | output | 1 | One-cycle pulse: a completed codeword had no table entry |
| overflow_err | output | 1 | One-cycle pulse: codeword exceeded the register length |

## Verification
The emission of a decoded character and the capture of the first bit of the following character can fall in the same cycle. The registered output of one gap lands on the edge where the framer takes the next leading one. The bench drives whole sentences with the strobe high on every cycle, so this collision happens between every pair of characters. A scoreboard then requires each character in order, in exactly the cycle after its gap strobe. The same timing check is applied with idle cycles and toggling data between strobes, and around the 12-bit overflow edge.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

  typedef enum logic [1:0] {
    FR_IDLE    = 2'd0,
    FR_COLLECT = 2'd1,
    FR_DISCARD = 2'd2
  } fr_state_e;

  typedef struct packed {
    logic       hit;
    logic [7:0] ch;
  } lookup_t;

  // Codeword value: first received bit is the most significant one bit.
  function automatic lookup_t vc_lookup(input logic [15:0] code);
    lookup_t r;
    r.hit = 1'b1;
    r.ch  = 8'h00;
    case (code)
      16'b1:          r.ch = 8'h20;
      16'b11101:      r.ch = 8'h0A;
      16'b11111:      r.ch = 8'h0D;
      16'b11:         r.ch = "e";
      16'b101:        r.ch = "t";
      16'b111:        r.ch = "o";
      16'b1011:       r.ch = "a";
      16'b1101:       r.ch = "i";
      16'b1111:       r.ch = "n";
      16'b10101:      r.ch = "r";
      16'b10111:      r.ch = "s";
      16'b11011:      r.ch = "l";
      16'b101011:     r.ch = "h";
      16'b101101:     r.ch = "d";
      16'b101111:     r.ch = "c";
      16'b110111:     r.ch = "u";
      16'b111011:     r.ch = "m";
      16'b111101:     r.ch = "f";
      16'b111111:     r.ch = "p";
      16'b1011011:    r.ch = "g";
      16'b1011101:    r.ch = "y";
      16'b1011111:    r.ch = "b";
      16'b1101011:    r.ch = "w";
      16'b1111011:    r.ch = "v";
      16'b10111111:   r.ch = "k";
      16'b11011111:   r.ch = "x";
      16'b111101011:  r.ch = "j";
      16'b110111111:  r.ch = "q";
      16'b111010101:  r.ch = "z";
      16'b10110111:   r.ch = "0";
      16'b10111101:   r.ch = "1";
      16'b11101101:   r.ch = "2";
      16'b11111111:   r.ch = "3";
      16'b101110111:  r.ch = "4";
      16'b101011011:  r.ch = "5";
      16'b101101011:  r.ch = "6";
      16'b110101101:  r.ch = "7";
      16'b110101011:  r.ch = "8";
      16'b110110111:  r.ch = "9";
      default:        r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vdec_framer.sv
module vdec_framer
  import vdec_pkg::*;
#(
  parameter int CODE_MAX = 12,
  localparam int CNT_W   = $clog2(CODE_MAX + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_valid,
  input  logic                bit_in,
  output logic                gap_evt,
  output logic                ovf_evt,
  output logic [CODE_MAX-1:0] code_word
);

  fr_state_e           state_q;
  logic [CODE_MAX-1:0] sr_q;
  logic [CNT_W-1:0]    len_q;
  logic                pend_q;   // one zero seen, not yet known to be a gap

  logic [CNT_W:0]      len_next;
  logic                fits;

  // Length after appending a one, counting a pending zero.
  function automatic logic [CNT_W:0] grow_len(input logic [CNT_W-1:0] len,
                                              input logic pend);
    return {1'b0, len} + (pend ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
  endfunction

  // Append a one, preceded by the pending zero if there is one.
  function automatic logic [CODE_MAX-1:0] push_one(input logic [CODE_MAX-1:0] sr,
                                                   input logic pend);
    return pend ? {sr[CODE_MAX-3:0], 2'b01} : {sr[CODE_MAX-2:0], 1'b1};
  endfunction

  assign len_next  = grow_len(len_q, pend_q);
  assign fits      = (len_next <= (CNT_W+1)'(CODE_MAX));
  assign gap_evt   = bit_valid && !bit_in && pend_q && (state_q == FR_COLLECT);
  assign ovf_evt   = bit_valid && bit_in && !fits && (state_q == FR_COLLECT);
  assign code_word = sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      sr_q    <= '0;
      len_q   <= '0;
      pend_q  <= 1'b0;
    end else if (bit_valid) begin
      case (state_q)
        FR_IDLE: begin
          if (bit_in) begin
            state_q <= FR_COLLECT;
            sr_q    <= CODE_MAX'(1);
            len_q   <= CNT_W'(1);
            pend_q  <= 1'b0;
          end
        end
        FR_COLLECT: begin
          if (!bit_in) begin
            if (pend_q) begin
              state_q <= FR_IDLE;
              sr_q    <= '0;
              len_q   <= '0;
              pend_q  <= 1'b0;
            end else begin
              pend_q <= 1'b1;
            end
          end else if (fits) begin
            sr_q   <= push_one(sr_q, pend_q);
            len_q  <= len_next[CNT_W-1:0];
            pend_q <= 1'b0;
          end else begin
            state_q <= FR_DISCARD;
            sr_q    <= '0;
            len_q   <= '0;
            pend_q  <= 1'b0;
          end
        end
        FR_DISCARD: begin
          if (!bit_in) begin
            if (pend_q) begin
              state_q <= FR_IDLE;
              pend_q  <= 1'b0;
            end else begin
              pend_q <= 1'b1;
            end
          end else begin
            pend_q <= 1'b0;
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  // R7: collected length never exceeds the register
  a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
    len_q <= CNT_W'(CODE_MAX));

  // R2: a zero while idle leaves the framer idle and empty
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_IDLE && bit_valid && !bit_in) |=> (state_q == FR_IDLE && len_q == '0));

  // R5: without a strobe nothing moves
  a_r5_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(sr_q) && $stable(state_q) && $stable(pend_q) && $stable(len_q)));

  // R4: a lone zero keeps the codeword open
  a_r4_single_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_COLLECT && bit_valid && !bit_in && !pend_q) |=> (state_q == FR_COLLECT && pend_q));

endmodule

// File: rtl/vdec_emit.sv
module vdec_emit
  import vdec_pkg::*;
#(
  parameter int CODE_MAX = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gap_evt,
  input  logic                ovf_evt,
  input  logic [CODE_MAX-1:0] code_word,
  output logic                char_valid,
  output logic [7:0]          char_out,
  output logic                unknown_code,
  output logic                overflow_err
);

  logic [15:0] code16;
  lookup_t     look_w;

  generate
    if (CODE_MAX < 16) begin : g_pad
      assign code16 = {{(16-CODE_MAX){1'b0}}, code_word};
    end else begin : g_trim
      assign code16 = code_word[15:0];
    end
  endgenerate

  assign look_w = vc_lookup(code16);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_valid   <= 1'b0;
      char_out     <= 8'h00;
      unknown_code <= 1'b0;
      overflow_err <= 1'b0;
    end else begin
      char_valid   <= gap_evt && look_w.hit;
      unknown_code <= gap_evt && !look_w.hit;
      overflow_err <= ovf_evt;
      if (gap_evt && look_w.hit) char_out <= look_w.ch;
    end
  end

  // R6: at most one kind of result per cycle
  a_r6_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({char_valid, unknown_code, overflow_err}));

  // R3: every gap yields a character or an unknown flag on the next edge
  a_r3_gap_answer: assert property (@(posedge clk) disable iff (rst)
    gap_evt |=> (char_valid ^ unknown_code));

  // R3: a character pulse lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  // R7: overflow flags and never emits a character
  a_r7_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (overflow_err && !char_valid));

endmodule

// File: rtl/vdec_top.sv
module vdec_top #(
  parameter int CODE_MAX = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       char_valid,
  output logic [7:0] char_out,
  output logic       unknown_code,
  output logic       overflow_err
);

  logic                gap_evt;
  logic                ovf_evt;
  logic [CODE_MAX-1:0] code_word;

  vdec_framer #(.CODE_MAX(CODE_MAX)) framer_i (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .gap_evt   (gap_evt),
    .ovf_evt   (ovf_evt),
    .code_word (code_word)
  );

  vdec_emit #(.CODE_MAX(CODE_MAX)) emit_i (
    .clk          (clk),
    .rst          (rst),
    .gap_evt      (gap_evt),
    .ovf_evt      (ovf_evt),
    .code_word    (code_word),
    .char_valid   (char_valid),
    .char_out     (char_out),
    .unknown_code (unknown_code),
    .overflow_err (overflow_err)
  );

  // R1: nothing is reported in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!char_valid && !unknown_code && !overflow_err && char_out == 8'h00));

endmodule

// File: tb/vdec_top_tb_top.sv
`timescale 1ns/1ps
module vdec_top_tb_top;

  localparam int K_CHAR = 0;
  localparam int K_UNK  = 1;
  localparam int K_OVF  = 2;

  typedef struct {
    int         kind;
    logic [7:0] ch;
    int         cyc;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       char_valid;
  logic [7:0] char_out;
  logic       unknown_code;
  logic       overflow_err;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vdec_top dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .char_valid(char_valid), .char_out(char_out),
    .unknown_code(unknown_code), .overflow_err(overflow_err)
  );

  // Bench-side encoder, written from the requirement table (R9)
  function automatic string enc(input byte c);
    case (c)
      8'h20: return "1";     8'h0A: return "11101";  8'h0D: return "11111";
      "e": return "11";      "t": return "101";      "o": return "111";
      "a": return "1011";    "i": return "1101";     "n": return "1111";
      "r": return "10101";   "s": return "10111";    "l": return "11011";
      "h": return "101011";  "d": return "101101";   "c": return "101111";
      "u": return "110111";  "m": return "111011";   "f": return "111101";
      "p": return "111111";  "g": return "1011011";  "y": return "1011101";
      "b": return "1011111"; "w": return "1101011";  "v": return "1111011";
      "k": return "10111111"; "x": return "11011111"; "j": return "111101011";
      "q": return "110111111"; "z": return "111010101";
      "0": return "10110111"; "1": return "10111101"; "2": return "11101101";
      "3": return "11111111"; "4": return "101110111"; "5": return "101011011";
      "6": return "101101011"; "7": return "110101101"; "8": return "110101011";
      "9": return "110110111";
      default: return "";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive_bit(input bit b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = i[0];
    end
  endtask

  task automatic push(input int kind, input logic [7:0] ch, input string req);
    exp_t e;
    e.kind = kind; e.ch = ch; e.cyc = cyc + 1; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drive_str(input string s, input int gaps);
    for (int i = 0; i < s.len(); i++) begin
      drive_bit(s[i] == "1");
      if (gaps > 0) idle(gaps);
    end
  endtask

  // Send a codeword then the gap; scoreboard entry at the last gap zero
  task automatic send_code(input string s, input int kind, input logic [7:0] ch,
                           input string req, input int gaps);
    drive_str(s, gaps);
    drive_bit(1'b0);
    if (gaps > 0) idle(gaps);
    drive_bit(1'b0);
    push(kind, ch, req);
  endtask

  task automatic send_text(input string t, input string req, input int gaps);
    for (int i = 0; i < t.len(); i++) send_code(enc(t[i]), K_CHAR, t[i], req, gaps);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && (char_valid || unknown_code || overflow_err)) begin
      int kind;
      kind = char_valid ? K_CHAR : (unknown_code ? K_UNK : K_OVF);
      if (sb.size() == 0) begin
        check(1'b0, "R2/R5", "unexpected output kind", kind, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(kind == e.kind, e.req, "kind", kind, e.kind);
        check(cyc == e.cyc, e.req, "cycle", cyc, e.cyc);
        if (e.kind == K_CHAR) check(char_out == e.ch, e.req, "char", char_out, e.ch);
        check($countones({char_valid, unknown_code, overflow_err}) == 1, e.req,
              "single flag", $countones({char_valid, unknown_code, overflow_err}), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(char_valid == 0 && unknown_code == 0 && overflow_err == 0, "R1", "flags", char_valid, 0);
    check(char_out == 8'h00, "R1", "char_out", char_out, 0);

    // R2: idle zeros ignored, then a character
    drive_str("0000", 0);
    send_text("e", "R2", 0);
    idle(3);

    // R9/R10: back-to-back strobes, whole table
    send_text("the quick brown fox jumps over the lazy dog", "R10", 0);
    send_text("0123456789", "R9", 0);
    send_code(enc(8'h0A), K_CHAR, 8'h0A, "R9", 0);
    send_code(enc(8'h0D), K_CHAR, 8'h0D, "R9", 0);
    // extra zeros between characters are idle zeros
    drive_str("000", 0);
    idle(2);

    // R4: single zero inside codeword
    send_code("101", K_CHAR, "t", "R4", 0);
    send_code("1110101", K_UNK, 8'h00, "R4", 0);

    // R5: idle cycles with toggling data between strobes
    send_text("zap", "R5", 3);

    // R6: unknown codeword
    send_code("1101101", K_UNK, 8'h00, "R6", 0);

    // R8: exactly 12 bits, no overflow
    send_code("111111111111", K_UNK, 8'h00, "R8", 0);

    // R7: thirteenth one overflows
    drive_str("111111111111", 0);
    drive_bit(1'b1);
    push(K_OVF, 8'h00, "R7");
    drive_str("1101100", 0);
    send_text("t", "R7", 0);

    // R7: pending zero counts toward the limit
    drive_str("11111111111", 0);
    drive_bit(1'b0);
    drive_bit(1'b1);
    push(K_OVF, 8'h00, "R7");
    drive_str("00", 0);
    send_text("a", "R7", 0);

    // R1: mid-codeword reset discards partial codeword
    drive_str("1011", 0);
    @(negedge clk);
    bit_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive_str("00", 0);
    idle(2);
    check(char_valid == 0 && unknown_code == 0, "R1", "after reset", char_valid, 0);
    send_text("n", "R1", 0);

    idle(5);
    check(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule